// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream and forwards only the packets whose packet identifier (PID) is wanted. It locks onto a packet when it sees a byte flagged as start-of-packet that holds the sync value 0x47. It then counts 188 bytes and takes the 13-bit PID from the second and third header bytes. Eight programmable slots each hold a PID and an enable bit. A packet goes through whole when an enabled slot holds its PID, and is dropped whole when none does.

Accepted packets leave the block as 32-bit words, 47 per packet. The first word of each packet is flagged. The four header bytes make up exactly the first word, so the decision is ready by the time that word is complete. Slot 0 also holds three global controls: pass every packet, turn PID filtering off, and choose the byte order inside each output word. Software writes the slots through a simple register port. The new settings are taken up only between packets.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset every slot reads back 0x0000_1FFF (PID 0x1FFF, enable and controls clear) and no output word is valid.
- R2: A packet whose PID equals the PID field (bits 12:0) of a slot whose enable bit (bit 15) is set is forwarded as 47 words, in order, with out_sop set on the first word only.
- R3: A slot with its enable bit clear never matches, even when its PID field equals the packet PID, and a packet that matches no slot produces no output word.
- R4: When bit 16 of slot 0 is set, every packet is forwarded, whatever the slot matches.
- R5: When bit 13 of slot 0 is set, PID filtering is off and every packet is forwarded.
- R6: With bit 14 of slot 0 clear, the earliest byte of each group of four goes to out_word[31:24]. With it set, the earliest byte goes to out_word[7:0] and the latest to out_word[31:24].
- R7: The PID is the low 5 bits of header byte 1 followed by all 8 bits of header byte 2. The upper 3 bits of byte 1 have no effect on the match.
- R8: A packet starts only on a valid byte that has in_sop set and the value 0x47. A start-of-packet byte holding any other value, and all bytes after it up to the next such start, produce no output.
- R9: A write to byte offset 4×n stores into slot n. Slots 1 to 7 keep only bits 15 and 12:0. Slot 0 also keeps bits 16, 14 and 13. The stored value reads back, zero-extended, from the cycle after the write.
- R10: A register write made in or after the cycle of a packet's sync byte does not change how that packet is filtered or packed. It applies from the next packet.
- R11: Only cycles with in_valid high advance the 188-byte count. Inside a packet, in_sop and the value 0x47 are treated as ordinary data. Output words are never valid on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset; slot n at 4×n |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the slot selected by cfg_addr |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte flagged as start of packet |
| in_data | input | 8 | Input stream byte |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is the first of a packet |
| out_word | output | 32 | Four packed bytes of an accepted packet |

## Verification
A corrupted byte counter or a sync state stuck in the wrong phase shows at the ports within one packet. Words come out misaligned, so the first word no longer carries 0x47 in the lane the byte-order bit selects, or the word count per packet is not 47. A wrong pass decision or a lost per-packet verdict appears as missing words or extra words on the fourth byte of the packet, one cycle after that byte is sampled. A configuration bank that does not hold still during a packet changes the byte lanes or the verdict of a packet already under way, and the following packet shows whether the write was taken up.

// File: rtl/ts_pf_pkg.sv
package ts_pf_pkg;

  localparam int          CFG_W     = 17;
  localparam int          PID_W     = 13;
  localparam logic [7:0]  SYNC_BYTE = 8'h47;

  localparam int BIT_BYPASS = 13;
  localparam int BIT_SWAP   = 14;
  localparam int BIT_EN     = 15;
  localparam int BIT_ALL    = 16;

  typedef logic [CFG_W-1:0] slot_cfg_t;

  localparam slot_cfg_t SLOT_PARKED = slot_cfg_t'(17'h01FFF);

  // bits a slot keeps; the global controls exist in slot 0 only
  function automatic slot_cfg_t keep_mask(input logic is_slot0);
    slot_cfg_t m;
    m = '0;
    m[PID_W-1:0] = '1;
    m[BIT_EN]    = 1'b1;
    if (is_slot0) begin
      m[BIT_BYPASS] = 1'b1;
      m[BIT_SWAP]   = 1'b1;
      m[BIT_ALL]    = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [PID_W-1:0] header_pid(input logic [7:0] hb1,
                                                  input logic [7:0] hb2);
    return {hb1[4:0], hb2};
  endfunction

  function automatic logic slot_hit(input slot_cfg_t c, input logic [PID_W-1:0] pid);
    return c[BIT_EN] && (c[PID_W-1:0] == pid);
  endfunction

  // e0 is the earliest byte of the group
  function automatic logic [31:0] lane_pack(input logic [7:0] e0, input logic [7:0] e1,
                                            input logic [7:0] e2, input logic [7:0] e3,
                                            input logic swap);
    return swap ? {e3, e2, e1, e0} : {e0, e1, e2, e3};
  endfunction

endpackage

// File: rtl/ts_pf_regs.sv
module ts_pf_regs
  import ts_pf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [31:0]                cfg_wdata,
  input  logic                       load_en,
  output logic [31:0]                cfg_rdata,
  output logic [NUM_SLOTS*CFG_W-1:0] act_flat
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]           sel;
  logic [NUM_SLOTS*CFG_W-1:0] shadow_flat;
  logic                       unused_bits;

  assign sel         = cfg_addr[ADDR_W-1:2];
  assign unused_bits = ^{cfg_addr[1:0], cfg_wdata[31:CFG_W]};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_cfg_t shadow_q;
    slot_cfg_t active_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= SLOT_PARKED;
        active_q <= SLOT_PARKED;
      end else begin
        if (cfg_we && (sel == IDX_W'(i)))
          shadow_q <= cfg_wdata[CFG_W-1:0] & keep_mask(i == 0);
        if (load_en)
          active_q <= shadow_q;
      end
    end
    assign shadow_flat[i*CFG_W +: CFG_W] = shadow_q;
    assign act_flat[i*CFG_W +: CFG_W]    = active_q;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (sel == IDX_W'(i))
        cfg_rdata = {{(32-CFG_W){1'b0}}, shadow_flat[i*CFG_W +: CFG_W]};
  end

endmodule

// File: rtl/ts_pf_framer.sv
module ts_pf_framer
  import ts_pf_pkg::*;
#(
  parameter int PKT_BYTES = 188,
  parameter int CNT_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  output logic             take,
  output logic             pkt_start,
  output logic             in_pkt,
  output logic [CNT_W-1:0] idx
);
  typedef enum logic {ST_HUNT, ST_BODY} fr_state_t;

  fr_state_t        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_byte;

  assign in_pkt    = (st_q == ST_BODY);
  assign pkt_start = !in_pkt && in_valid && in_sop && (in_data == SYNC_BYTE);
  assign take      = pkt_start || (in_pkt && in_valid);
  assign idx       = in_pkt ? cnt_q : '0;
  assign last_byte = (cnt_q == CNT_W'(PKT_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
    end else if (!in_pkt) begin
      if (pkt_start) begin
        st_q  <= ST_BODY;
        cnt_q <= CNT_W'(1);
      end
    end else if (in_valid) begin
      if (last_byte) begin
        st_q  <= ST_HUNT;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ts_pf_match.sv
module ts_pf_match
  import ts_pf_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS*CFG_W-1:0] act_flat,
  input  logic [PID_W-1:0]           pid,
  output logic [NUM_SLOTS-1:0]       hit,
  output logic                       pass
);
  slot_cfg_t ctl0;
  logic      unused_cfg;

  assign ctl0       = act_flat[CFG_W-1:0];
  assign unused_cfg = ^act_flat;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign hit[i] = slot_hit(act_flat[i*CFG_W +: CFG_W], pid);
  end

  assign pass = (|hit) || ctl0[BIT_ALL] || ctl0[BIT_BYPASS];

endmodule

// File: rtl/ts_pf_packer.sv
module ts_pf_packer
  import ts_pf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       in_data,
  input  logic             swap,
  input  logic             hdr_pass,
  output logic [PID_W-1:0] hdr_pid,
  output logic             pkt_pass,
  output logic             out_valid,
  output logic             out_sop,
  output logic [31:0]      out_word
);
  logic [23:0] acc_q;
  logic        pass_q;
  logic        word_end;
  logic        hdr_end;
  logic        keep;

  assign word_end = take && (idx[1:0] == 2'd3);
  assign hdr_end  = take && (idx == CNT_W'(3));
  assign keep     = hdr_end ? hdr_pass : pass_q;
  assign hdr_pid  = header_pid(acc_q[15:8], acc_q[7:0]);
  assign pkt_pass = pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      pass_q    <= 1'b0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_word  <= '0;
    end else begin
      if (take && !word_end)
        acc_q <= {acc_q[15:0], in_data};
      if (hdr_end)
        pass_q <= hdr_pass;
      out_valid <= word_end && keep;
      out_sop   <= hdr_end && hdr_pass;
      if (word_end && keep)
        out_word <= lane_pack(acc_q[23:16], acc_q[15:8], acc_q[7:0], in_data, swap);
    end
  end

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_pf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PKT_BYTES = 188,
  parameter int ADDR_W    = $clog2(NUM_SLOTS) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic [31:0]       out_word
);
  localparam int CNT_W = $clog2(PKT_BYTES);

  logic [NUM_SLOTS*CFG_W-1:0] act_flat;
  logic                       take;
  logic                       pkt_start;
  logic                       in_pkt;
  logic [CNT_W-1:0]           idx;
  logic [PID_W-1:0]           hdr_pid;
  logic [NUM_SLOTS-1:0]       slot_hits;
  logic                       hdr_pass;
  logic                       pkt_pass;
  logic                       cfg_swap;
  logic                       unused_evt;

  assign cfg_swap   = act_flat[BIT_SWAP];
  assign unused_evt = ^{pkt_start, slot_hits};

  ts_pf_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .load_en   (!in_pkt),
    .cfg_rdata (cfg_rdata),
    .act_flat  (act_flat)
  );

  ts_pf_framer #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_data   (in_data),
    .take      (take),
    .pkt_start (pkt_start),
    .in_pkt    (in_pkt),
    .idx       (idx)
  );

  ts_pf_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .act_flat (act_flat),
    .pid      (hdr_pid),
    .hit      (slot_hits),
    .pass     (hdr_pass)
  );

  ts_pf_packer #(.CNT_W(CNT_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .idx       (idx),
    .in_data   (in_data),
    .swap      (cfg_swap),
    .hdr_pass  (hdr_pass),
    .hdr_pid   (hdr_pid),
    .pkt_pass  (pkt_pass),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_word  (out_word)
  );

endmodule

// File: rtl/ts_pf_checker.sv
module ts_pf_checker
  import ts_pf_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_pkt,
  input logic                       cfg_swap,
  input logic                       pkt_pass,
  input logic [NUM_SLOTS*CFG_W-1:0] act_flat,
  input logic                       out_valid,
  input logic                       out_sop,
  input logic [31:0]                out_word
);

  AST_SOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid); // R2

  AST_BODY_NEEDS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> pkt_pass); // R3

  AST_SYNC_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (cfg_swap ? (out_word[7:0] == SYNC_BYTE) : (out_word[31:24] == SYNC_BYTE))); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && $past(in_pkt)) |-> $stable(act_flat)); // R10

  AST_WORD_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R11

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R11

endmodule

bind ts_pid_filter ts_pf_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_pkt    (in_pkt),
  .cfg_swap  (cfg_swap),
  .pkt_pass  (pkt_pass),
  .act_flat  (act_flat),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_word  (out_word)
);

// File: tb/ts_pid_filter_test.sv
module ts_pid_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_sop;
  logic [31:0] out_word;

  always #5 clk = ~clk;

  ts_pid_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_sop(in_sop), .in_data(in_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_word(out_word)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] got_w[$];
  logic        got_s[$];
  logic [31:0] exp_w[$];

  // table entry: {all, swap, bypass, pid[12:0], expect_forward}
  localparam int NVEC = 9;
  localparam logic [16:0] VEC [NVEC] = '{
    {3'b000, 13'h0100, 1'b1},
    {3'b000, 13'h0155, 1'b1},
    {3'b000, 13'h1FFF, 1'b0},
    {3'b000, 13'h0200, 1'b0},
    {3'b100, 13'h0200, 1'b1},
    {3'b001, 13'h0200, 1'b1},
    {3'b010, 13'h0166, 1'b1},
    {3'b010, 13'h0201, 1'b0},
    {3'b000, 13'h0122, 1'b1}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4:       return "R4";
      5:       return "R5";
      6, 7:    return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got_w.push_back(out_word);
      got_s.push_back(out_sop);
    end
  end

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata == exp, cfg_rdata, exp);
  endtask

  task automatic send_pkt(input logic [12:0] pid, input logic [7:0] seed, input bit gaps,
                          input bit fwd, input bit swap);
    logic [7:0] b [188];
    b[0] = 8'h47;
    b[1] = {3'b101, pid[12:8]};
    b[2] = pid[7:0];
    b[3] = 8'h10 ^ seed;
    for (int k = 4; k < 188; k++) b[k] = 8'(k * 3) + seed;
    if (gaps) b[100] = 8'h47;
    if (fwd)
      for (int w = 0; w < 47; w++)
        exp_w.push_back(swap ? {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]}
                             : {b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]});
    for (int k = 0; k < 188; k++) begin
      if (gaps && (k % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (k == 0) || (gaps && k == 100);
      in_data  = b[k];
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic compare_out(input string req);
    int bad;
    int sops;
    repeat (4) @(negedge clk);
    chk(req, got_w.size() == exp_w.size(), 32'(got_w.size()), 32'(exp_w.size()));
    bad = -1;
    for (int i = 0; i < got_w.size() && i < exp_w.size(); i++)
      if (bad < 0 && got_w[i] !== exp_w[i]) bad = i;
    if (bad >= 0) chk(req, 1'b0, got_w[bad], exp_w[bad]);
    else          chk(req, 1'b1, '0, '0);
    sops = 0;
    for (int i = 0; i < got_s.size(); i++) if (got_s[i]) sops++;
    chk(req, (sops == (exp_w.size() > 0 ? 1 : 0)) && (got_s.size() == 0 || got_s[0]),
        32'(sops), (exp_w.size() > 0) ? 32'd1 : 32'd0);
    got_w.delete(); got_s.delete(); exp_w.delete();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1", out_valid == 1'b0, 32'(out_valid), 32'd0);
    for (int s = 0; s < 8; s++) rd_chk(5'(s * 4), 32'h0000_1FFF, "R1");

    // R9: per-slot write masks and readback
    wr(5'd12, 32'hFFFF_FFFF);
    rd_chk(5'd12, 32'h0000_9FFF, "R9");
    wr(5'd0, 32'hFFFF_FFFF);
    rd_chk(5'd0, 32'h0001_FFFF, "R9");
    rd_chk(5'd4, 32'h0000_1FFF, "R9");

    // slot n enabled at PID 0x100 + n*0x11, slot 7 parked
    for (int s = 0; s < 7; s++) wr(5'(s * 4), 32'h0000_8000 | 32'(13'h100 + 13'(s * 17)));
    wr(5'd28, 32'h0000_1FFF);

    // table-driven: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] ctl;
      ctl = VEC[v][16:14];
      wr(5'd0, {15'd0, ctl[2], 1'b1, ctl[1], ctl[0], 13'h0100});
      repeat (2) @(negedge clk);
      send_pkt(VEC[v][13:1], 8'(v * 29), 1'b0, VEC[v][0], ctl[1]);
      compare_out(vec_req(v));
    end
    wr(5'd0, 32'h0000_8100);

    // R8: bad start byte and unflagged sync values produce nothing
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_data = 8'h46;
    for (int k = 0; k < 190; k++) begin
      @(negedge clk);
      in_sop  = 1'b0;
      in_data = (k % 9 == 0) ? 8'h47 : 8'(k);
    end
    @(negedge clk);
    in_valid = 1'b0;
    compare_out("R8");
    send_pkt(13'h0100, 8'h5A, 1'b0, 1'b1, 1'b0);
    compare_out("R8");

    // R11: idle gaps and a flagged 0x47 inside the body
    send_pkt(13'h0133, 8'h3C, 1'b1, 1'b1, 1'b0);
    compare_out("R11");
    send_pkt(13'h0144, 8'h21, 1'b0, 1'b1, 1'b0);
    compare_out("R11");

    // R10: disabling slot 1 mid-packet leaves that packet forwarded
    fork
      send_pkt(13'h0111, 8'h77, 1'b0, 1'b1, 1'b0);
      begin
        repeat (20) @(negedge clk);
        wr(5'd4, 32'h0000_1FFF);
      end
    join
    compare_out("R10");
    send_pkt(13'h0111, 8'h78, 1'b0, 1'b0, 1'b0);
    compare_out("R10");

    // R10: byte-order change mid-packet applies from the next packet
    fork
      send_pkt(13'h0122, 8'h13, 1'b0, 1'b1, 1'b0);
      begin
        repeat (30) @(negedge clk);
        wr(5'd0, 32'h0000_C100);
      end
    join
    compare_out("R10");
    send_pkt(13'h0122, 8'h14, 1'b0, 1'b1, 1'b1);
    compare_out("R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule